// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Device Model

This block is a synthesizable, cycle-level model of a byte-wide one-time-programmable memory device that has a two-line control interface. A surrounding test environment or emulated board drives it the way a host would drive the real device. It supplies an address, an active-low chip enable, and a two-bit level code on the combined output-enable/programming-voltage line. It also supplies a flag that marks a high identification voltage on address line 9, and a flag that says the supply sits at its programming level. From these inputs the block decodes the following modes: read, output disable, standby, program, program verify, program inhibit and identification.

The three analog access delays (address to data, chip enable to data, output enable to data) and the float delay are integer counts of clock cycles. While an access has not yet matured, the bus keeps its previous byte and its previous drive state. Programming only ANDs the input byte into the stored byte, so a cleared bit can never be set again. The array depth is a parameter. Address bits above the depth alias onto the array.

Top module: `otp_mem_model`

## Requirements
- R1: After synchronous reset, `dout_en` is 0, `dout` is 0x00 and every cell reads back 0xFF.
- R2: With `supply_prog`=0, `ce_n`=0, `oe_lvl`=0 (low) and `a9_hv`=0, the block drives the byte stored at index `addr mod DEPTH` on `dout` with `dout_en`=1.
- R3: A driving mode loads `dout` and sets `dout_en` only at the edge where three conditions all hold: `{a9_hv,addr}` has been sampled unchanged for T_ACC consecutive edges, `ce_n` low for T_CE, and `oe_lvl`=0 for T_OE. Before that edge, `dout` and `dout_en` keep their previous values.
- R4: In a non-driving mode other than program, `dout_en` falls at the T_DF-th consecutive edge spent in such modes, and `dout` keeps its last byte. These modes are output disable (`oe_lvl`=1, `ce_n`=0), standby (`ce_n`=1 with supply normal), inhibit and invalid.
- R5: Program mode (`supply_prog`=1, `ce_n`=0, `oe_lvl`=2) replaces the addressed cell with cell AND `din` at every edge, and it clears `dout_en` at the first edge.
- R6: Verify mode (`supply_prog`=1, `ce_n`=0, `oe_lvl`=0) drives the stored byte with the same delays as a read.
- R7: Program inhibit (`supply_prog`=1, `ce_n`=1, `oe_lvl`=2) writes nothing and floats the bus as in R4.
- R8: Identification mode is entered with `a9_hv`=1, `supply_prog`=0, `ce_n`=0 and `oe_lvl`=0, and every address bit other than bits 0 and 9 at 0. In this mode the block returns 0x1E when `addr[0]`=0 and 0x0D when `addr[0]`=1.
- R9: The following combinations decode as invalid: `oe_lvl`=3; `oe_lvl`=2 with `supply_prog`=0; `a9_hv`=1 when some other address bit is set, or together with `supply_prog`=1; and `oe_lvl`=1 or `ce_n`=1 with `oe_lvl`=0 in the programming supply. An invalid combination never changes the array and floats the bus as in R4.
- R10: A bit that reads as 0 never reads as 1 again until reset, whatever `din` is programmed later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip enable, active low |
| oe_lvl | input | 2 | Output-enable line level: 0 low, 1 high, 2 programming voltage, 3 reserved |
| a9_hv | input | 1 | Identification high voltage present on address line 9 |
| supply_prog | input | 1 | Supply at programming level |
| din | input | DATA_W | Byte to program |
| dout | output | DATA_W | Byte driven by the device |
| dout_en | output | 1 | Device drives the data bus |

## Verification
Suppose a wrong decode or a write that leaks into the wrong mode corrupts the array. The corruption stays hidden until a later read or verify of the affected index, so the random phase keeps returning to a small set of indices and to aliased addresses. A miscounted delay shows up at once: the byte or the drive flag changes one edge early or late. The directed checks therefore sample one cycle before and at the exact edge predicted by the stated cycle counts. A broken identification decode returns array contents instead of the fixed codes on the first matured access.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [1:0] {
        OE_LOW  = 2'd0,
        OE_HIGH = 2'd1,
        OE_VPP  = 2'd2,
        OE_RSVD = 2'd3
    } oe_lvl_e;

    typedef enum logic [2:0] {
        M_INVALID,
        M_READ,
        M_DISABLE,
        M_STANDBY,
        M_PROG,
        M_VERIFY,
        M_INHIBIT,
        M_ID
    } otp_mode_e;

    localparam logic [7:0] ID_MFR = 8'h1E;
    localparam logic [7:0] ID_DEV = 8'h0D;

    typedef struct packed {
        logic    supply_prog;
        logic    ce_n;
        oe_lvl_e oe;
        logic    id_hv;
        logic    id_ok;
    } ctrl_t;

    function automatic otp_mode_e decode_mode(input ctrl_t c);
        otp_mode_e m;
        m = M_INVALID;
        if (c.oe == OE_RSVD) begin
            m = M_INVALID;
        end else if (!c.supply_prog) begin
            if (c.ce_n) begin
                m = (c.oe == OE_VPP) ? M_INVALID : M_STANDBY;
            end else begin
                case (c.oe)
                    OE_LOW:  m = c.id_hv ? (c.id_ok ? M_ID : M_INVALID) : M_READ;
                    OE_HIGH: m = M_DISABLE;
                    default: m = M_INVALID;
                endcase
            end
        end else if (c.id_hv) begin
            m = M_INVALID;
        end else if (c.ce_n) begin
            m = (c.oe == OE_VPP) ? M_INHIBIT : M_INVALID;
        end else begin
            case (c.oe)
                OE_LOW:  m = M_VERIFY;
                OE_VPP:  m = M_PROG;
                default: m = M_INVALID;
            endcase
        end
        return m;
    endfunction

    function automatic logic is_drive(input otp_mode_e m);
        return (m == M_READ) || (m == M_VERIFY) || (m == M_ID);
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ID_PIN = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic [1:0]        oe_lvl,
    input  logic              a9_hv,
    input  logic              supply_prog,
    output otp_mode_e         mode
);
    localparam logic [ADDR_W-1:0] ID_FREE_BITS =
        (ADDR_W'(1) << ID_PIN) | ADDR_W'(1);

    ctrl_t ctrl;

    always_comb begin
        ctrl.supply_prog = supply_prog;
        ctrl.ce_n        = ce_n;
        ctrl.oe          = oe_lvl_e'(oe_lvl);
        ctrl.id_hv       = a9_hv;
        ctrl.id_ok       = ((addr & ~ID_FREE_BITS) == '0);
        mode             = decode_mode(ctrl);
    end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_mask,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en) begin
            cells[idx] <= cells[idx] & wr_mask;
        end
    end

    assign rd_data = cells[idx];

endmodule

// File: rtl/otp_out_timer.sv
module otp_out_timer
    import otp_pkg::*;
#(
    parameter int KEY_W  = 17,
    parameter int DATA_W = 8,
    parameter int T_ACC  = 5,
    parameter int T_CE   = 5,
    parameter int T_OE   = 3,
    parameter int T_DF   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  otp_mode_e         mode,
    input  logic [KEY_W-1:0]  key,
    input  logic              ce_n,
    input  logic              oe_low,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int M_AC    = (T_ACC > T_CE) ? T_ACC : T_CE;
    localparam int M_OF    = (T_OE > T_DF) ? T_OE : T_DF;
    localparam int CNT_MAX = (M_AC > M_OF) ? M_AC : M_OF;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LIM_ACC = CNT_W'(T_ACC);
    localparam logic [CNT_W-1:0] LIM_CE  = CNT_W'(T_CE);
    localparam logic [CNT_W-1:0] LIM_OE  = CNT_W'(T_OE);
    localparam logic [CNT_W-1:0] LIM_DF  = CNT_W'(T_DF);
    localparam logic [CNT_W-1:0] LIM_MAX = CNT_W'(CNT_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] addr_age;
        logic [CNT_W-1:0] ce_age;
        logic [CNT_W-1:0] oe_age;
        logic [CNT_W-1:0] idle_age;
    } ages_t;

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
        return (v >= LIM_MAX) ? v : v + 1'b1;
    endfunction

    ages_t             age_q, age_d;
    logic [KEY_W-1:0]  key_q;
    logic [DATA_W-1:0] dout_q;
    logic              en_q;
    logic              drive, ready;

    always_comb begin
        drive          = is_drive(mode);
        age_d.addr_age = (key != key_q) ? CNT_W'(1) : bump(age_q.addr_age);
        age_d.ce_age   = ce_n   ? '0 : bump(age_q.ce_age);
        age_d.oe_age   = oe_low ? bump(age_q.oe_age) : '0;
        age_d.idle_age = drive  ? '0 : bump(age_q.idle_age);
        ready = (age_d.addr_age >= LIM_ACC) && (age_d.ce_age >= LIM_CE)
             && (age_d.oe_age >= LIM_OE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q  <= '0;
            age_q  <= '0;
            dout_q <= '0;
            en_q   <= 1'b0;
        end else begin
            key_q <= key;
            age_q <= age_d;
            if (mode == M_PROG) begin
                en_q <= 1'b0;
            end else if (drive) begin
                if (ready) begin
                    en_q   <= 1'b1;
                    dout_q <= data;
                end
            end else if (age_d.idle_age >= LIM_DF) begin
                en_q <= 1'b0;
            end
        end
    end

    assign dout    = dout_q;
    assign dout_en = en_q;

endmodule

// File: rtl/otp_mem_model.sv
module otp_mem_model
    import otp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256,
    parameter int ID_PIN = 9,
    parameter int T_ACC  = 5,
    parameter int T_CE   = 5,
    parameter int T_OE   = 3,
    parameter int T_DF   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic [1:0]        oe_lvl,
    input  logic              a9_hv,
    input  logic              supply_prog,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int KEY_W = ADDR_W + 1;

    otp_mode_e         mode;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] sel_data;

    assign idx = addr[IDX_W-1:0];

    otp_mode_decode #(.ADDR_W(ADDR_W), .ID_PIN(ID_PIN)) u_dec (
        .addr(addr), .ce_n(ce_n), .oe_lvl(oe_lvl), .a9_hv(a9_hv),
        .supply_prog(supply_prog), .mode(mode)
    );

    otp_cell_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst(rst), .wr_en(mode == M_PROG), .idx(idx),
        .wr_mask(din), .rd_data(rd_data)
    );

    always_comb begin
        if (mode == M_ID) begin
            sel_data = addr[0] ? DATA_W'(ID_DEV) : DATA_W'(ID_MFR);
        end else begin
            sel_data = rd_data;
        end
    end

    otp_out_timer #(
        .KEY_W(KEY_W), .DATA_W(DATA_W), .T_ACC(T_ACC), .T_CE(T_CE),
        .T_OE(T_OE), .T_DF(T_DF)
    ) u_tmr (
        .clk(clk), .rst(rst), .mode(mode), .key({a9_hv, addr}),
        .ce_n(ce_n), .oe_low(oe_lvl == 2'd0), .data(sel_data),
        .dout(dout), .dout_en(dout_en)
    );

endmodule

// File: rtl/otp_mem_model_chk.sv
module otp_mem_model_chk
    import otp_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input otp_mode_e         mode,
    input logic [IDX_W-1:0]  idx,
    input logic [DATA_W-1:0] rd_data,
    input logic              dout_en
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R5: the bus is released one edge after program mode is seen
    assert_prog_release_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == M_PROG) |=> !dout_en);

    // R3: the bus only starts driving out of a driving mode
    assert_drive_start_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $rose(dout_en) |-> is_drive($past(mode)));

    // R4: the bus only stops driving out of a non-driving mode
    assert_float_only_idle_R4: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $fell(dout_en) |-> !is_drive($past(mode)));

    // R9 and R7: no cell changes unless program mode was decoded
    assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (idx == $past(idx) && $past(mode) != M_PROG) |-> (rd_data == $past(rd_data)));

    // R10: a stored zero never turns back into a one
    assert_clear_only_R10: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (idx == $past(idx)) |-> ((rd_data & ~$past(rd_data)) == '0));

endmodule

bind otp_mem_model otp_mem_model_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .idx(idx), .rd_data(rd_data),
    .dout_en(dout_en)
);

// File: tb/otp_mem_model_test.sv
`timescale 1ns/1ps
module otp_mem_model_test;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        ce_n;
    logic [1:0]  oe_lvl;
    logic        a9_hv;
    logic        supply_prog;
    logic [7:0]  din;
    logic [7:0]  dout;
    logic        dout_en;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    otp_mem_model uut (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_lvl(oe_lvl),
        .a9_hv(a9_hv), .supply_prog(supply_prog), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [7:0] expect_cell(input logic [15:0] a);
        return model[a[7:0]];
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_en(input string req, input logic exp);
        checks++;
        if (dout_en !== exp) begin
            failures++;
            $display("FAIL %s dout_en actual=%b expected=%b t=%0t", req, dout_en, exp, $time);
        end
    endtask

    task automatic chk_dat(input string req, input logic [7:0] exp);
        checks++;
        if (dout !== exp) begin
            failures++;
            $display("FAIL %s dout actual=%h expected=%h t=%0t", req, dout, exp, $time);
        end
    endtask

    task automatic drive(input logic sp, input logic ce, input logic [1:0] oe,
                         input logic hv, input logic [15:0] a, input logic [7:0] d);
        supply_prog = sp; ce_n = ce; oe_lvl = oe; a9_hv = hv; addr = a; din = d;
    endtask

    task automatic program_byte(input logic [15:0] a, input logic [7:0] d);
        drive(1'b1, 1'b0, 2'd2, 1'b0, a, d);
        step(1);
        model[a[7:0]] = model[a[7:0]] & d;
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        rst = 1'b1;
        drive(1'b0, 1'b1, 2'd1, 1'b0, 16'h0000, 8'h00);
        step(3);
        rst = 1'b0;
        step(1);
        chk_en("R1", 1'b0);
        chk_dat("R1", 8'h00);

        // R2/R3: read from float, all three delays start together (max 5)
        drive(1'b0, 1'b0, 2'd0, 1'b0, 16'h0012, 8'h00);
        step(4);
        chk_en("R3", 1'b0);
        step(1);
        chk_en("R2", 1'b1);
        chk_dat("R1", 8'hFF);

        // R5: program twice, bus released after one edge
        program_byte(16'h0012, 8'hA5);
        chk_en("R5", 1'b0);
        program_byte(16'h0012, 8'h3C);

        // R6: verify, output enable delay of 3
        drive(1'b1, 1'b0, 2'd0, 1'b0, 16'h0012, 8'h00);
        step(2);
        chk_en("R6", 1'b0);
        step(1);
        chk_en("R6", 1'b1);
        chk_dat("R6", 8'h24);

        // R10: programming ones does not restore cleared bits
        program_byte(16'h0012, 8'hFF);
        drive(1'b1, 1'b0, 2'd0, 1'b0, 16'h0012, 8'h00);
        step(3);
        chk_dat("R10", 8'h24);

        // R3: address change holds old byte until T_ACC
        drive(1'b0, 1'b0, 2'd0, 1'b0, 16'h0013, 8'h00);
        step(4);
        chk_en("R3", 1'b1);
        chk_dat("R3", 8'h24);
        step(1);
        chk_dat("R3", 8'hFF);

        // R2: aliasing above the array depth
        drive(1'b0, 1'b0, 2'd0, 1'b0, 16'h0112, 8'h00);
        step(5);
        chk_dat("R2", 8'h24);

        // R4: output disable floats after T_DF, data held
        oe_lvl = 2'd1;
        step(1);
        chk_en("R4", 1'b1);
        chk_dat("R4", 8'h24);
        step(1);
        chk_en("R4", 1'b0);

        // R3: output enable alone restarts with T_OE
        oe_lvl = 2'd0;
        step(2);
        chk_en("R3", 1'b0);
        step(1);
        chk_en("R3", 1'b1);

        // R4: standby
        ce_n = 1'b1;
        step(1);
        chk_en("R4", 1'b1);
        step(1);
        chk_en("R4", 1'b0);

        // R8: identification codes
        drive(1'b0, 1'b0, 2'd0, 1'b1, 16'h0200, 8'h00);
        step(5);
        chk_dat("R8", 8'h1E);
        drive(1'b0, 1'b0, 2'd0, 1'b1, 16'h0201, 8'h00);
        step(5);
        chk_dat("R8", 8'h0D);
        chk_en("R8", 1'b1);

        // R9: identification with a stray address bit is invalid
        drive(1'b0, 1'b0, 2'd0, 1'b1, 16'h0204, 8'h00);
        step(2);
        chk_en("R9", 1'b0);

        // R7: inhibit writes nothing
        drive(1'b1, 1'b1, 2'd2, 1'b0, 16'h0013, 8'h00);
        step(3);
        chk_en("R7", 1'b0);
        drive(1'b1, 1'b0, 2'd0, 1'b0, 16'h0013, 8'h00);
        step(5);
        chk_dat("R7", 8'hFF);

        // R9: programming level without programming supply, and reserved code
        drive(1'b0, 1'b0, 2'd2, 1'b0, 16'h0013, 8'h00);
        step(3);
        chk_en("R9", 1'b0);
        drive(1'b1, 1'b0, 2'd3, 1'b0, 16'h0013, 8'h00);
        step(3);
        chk_en("R9", 1'b0);
        drive(1'b0, 1'b0, 2'd0, 1'b0, 16'h0013, 8'h00);
        step(6);
        chk_dat("R9", 8'hFF);

        // Random mix of program, read and verify over a few indices
        for (int it = 0; it < 120; it++) begin
            logic [15:0] a;
            int op;
            a = {8'($urandom), 5'b0, 3'($urandom)};
            op = int'($urandom % 3);
            if (op == 0) begin
                program_byte(a, 8'($urandom));
                chk_en("R5", 1'b0);
            end else begin
                drive(op == 2, 1'b0, 2'd0, 1'b0, a, 8'($urandom));
                step(6);
                chk_en(op == 2 ? "R6" : "R2", 1'b1);
                chk_dat(op == 2 ? "R6" : "R10", expect_cell(a));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule